// File: doc/BRIEF.md
# Receive Buffer with Threshold Interrupt

This block sits between a fast byte producer and a processor. Incoming bytes are stored in a 256-entry first-in first-out memory with no processor involvement. The processor empties the buffer through a read strobe, and the producer may keep writing while it does so. Three occupancy flags are visible at all times: nothing stored, at least half full, and completely full.

An interrupt request is raised when a selectable occupancy condition becomes true. Half full is the default source. The request is a level, and it stays up until the processor acknowledges it. After an acknowledge, the request comes back only when the selected condition goes from false to true again, so a processor that is still draining is not interrupted over and over. A byte that arrives while the buffer is full is dropped. The drop is recorded in a sticky overflow flag, which the processor clears with its own strobe.

Top module: `rx_fifo_irq`

## Requirements
- R1: Bytes accepted on the write port come out of the read port in the order they were written. `rd_data` shows the byte in the cycle after the edge at which `rd_en` was sampled with the buffer not empty. The buffer holds 256 bytes.
- R2: `empty` is 1 exactly when the buffer holds 0 bytes. `full` is 1 exactly when it holds 256 bytes. `half` is 1 when it holds 128 bytes or more. Each flag reflects a write or read in the cycle after the edge at which that write or read was sampled.
- R3: A write sampled while `full` is 1 is dropped and sets `ovf` at that edge. `ovf` then stays 1 until `ovf_clr` is sampled high. If a dropped write and `ovf_clr` fall on the same edge, `ovf` is set.
- R4: A read and a write sampled together on a buffer that is neither empty nor full both take effect, and the occupancy does not change.
- R5: A read sampled while the buffer is empty leaves `rd_data` unchanged and moves nothing: the next byte written is the next byte read.
- R6: `irq_sel` picks the interrupt source: 0 or 3 = half, 1 = full, 2 = not empty. `irq` goes to 1 at the edge after the edge at which the selected condition became true.
- R7: Once `irq` is 1, it stays 1 until `irq_ack` is sampled high. It is 0 in the following cycle, unless the source had a new false-to-true transition at that same edge.
- R8: After an acknowledge, `irq` stays 0 while the selected condition stays true. It asserts again only on a new false-to-true transition of that condition.
- R9: With `rst` sampled high, the buffer becomes empty and `ovf`, `irq` and `rd_data` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Producer write strobe |
| wr_data | input | 8 | Producer byte |
| rd_en | input | 1 | Processor read strobe |
| rd_data | output | 8 | Byte last read out |
| empty | output | 1 | Buffer holds no bytes |
| half | output | 1 | Buffer holds 128 bytes or more |
| full | output | 1 | Buffer holds 256 bytes |
| irq_sel | input | 2 | Interrupt source select |
| irq | output | 1 | Interrupt request level |
| irq_ack | input | 1 | Processor acknowledge |
| ovf | output | 1 | Sticky flag: a byte was dropped |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
The hardest case to reach is an acknowledge given while the source condition stays true, followed by a drain below the threshold and a refill above it. Only that sequence shows that the request comes back on a transition and not on the level. The stimulus reaches it with directed phases: fill to 256, acknowledge, hold, drain and refill. Random phases then bias the write and read rates toward filling or toward draining. This carries the occupancy repeatedly across the half and full boundaries while acknowledges, source changes and overflow clears arrive at random times.

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq #(
  parameter int DW    = 8,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          half,
  output logic          full,
  input  logic [1:0]    irq_sel,
  output logic          irq,
  input  logic          irq_ack,
  output logic          ovf,
  input  logic          ovf_clr
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          cond, cond_q;

  wire do_wr = wr_en & ~full;
  wire do_rd = rd_en & ~empty;
  wire rise  = cond & ~cond_q;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign half  = (cnt >= CW'(HALF));

  always_comb begin
    case (irq_sel)
      2'd1:    cond = full;
      2'd2:    cond = ~empty;
      default: cond = half;
    endcase
  end

  always_ff @(posedge clk)
    if (do_wr) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      rd_data <= '0;
      ovf     <= 1'b0;
      irq     <= 1'b0;
      cond_q  <= 1'b0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) begin
        rd_data <= mem[rp];
        rp      <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
      if (do_wr && !do_rd)      cnt <= cnt + 1'b1;
      else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
      if (wr_en && full)        ovf <= 1'b1;
      else if (ovf_clr)         ovf <= 1'b0;
      irq    <= rise | (irq & ~irq_ack);
      cond_q <= cond;
    end
  end
endmodule

module rx_fifo_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       empty,
  input logic       half,
  input logic       full,
  input logic [1:0] irq_sel,
  input logic       irq,
  input logic       irq_ack,
  input logic       ovf,
  input logic       ovf_clr
);
  logic sel_c;
  assign sel_c = (irq_sel == 2'd1) ? full : (irq_sel == 2'd2) ? !empty : half;

  p_flags_excl_r2: assert property (@(posedge clk) disable iff (rst) !(empty && full));
  p_full_half_r2:  assert property (@(posedge clk) disable iff (rst) full |-> half);
  p_ovf_set_r3:    assert property (@(posedge clk) disable iff (rst) (wr_en && full) |=> ovf);
  p_ovf_keep_r3:   assert property (@(posedge clk) disable iff (rst) (ovf && !ovf_clr) |=> ovf);
  p_rd_empty_r5:   assert property (@(posedge clk) disable iff (rst) (rd_en && empty) |=> $stable(rd_data));
  p_irq_hold_r7:   assert property (@(posedge clk) disable iff (rst) (irq && !irq_ack) |=> irq);
  p_no_storm_r8:   assert property (@(posedge clk) disable iff (rst)
                     (irq && irq_ack && sel_c && $past(sel_c)) |=> !irq);
  p_reset_r9:      assert property (@(posedge clk) rst |=> (empty && !irq && !ovf && rd_data == 8'd0));
endmodule

bind rx_fifo_irq rx_fifo_irq_chk u_chk (.*);

// File: tb/rx_fifo_irq_bench.sv
`timescale 1ns/1ps
module rx_fifo_irq_bench;
  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0, irq_ack = 0, ovf_clr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] irq_sel = 0;
  logic [7:0] rd_data;
  logic empty, half, full, irq, ovf;
  int total = 0, bad = 0;

  byte unsigned q[$];
  logic [7:0] m_rd = 0;
  bit m_ovf = 0, m_irq = 0, m_cq = 0;

  always #5 clk = ~clk;

  rx_fifo_irq u_rx_fifo_irq (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_cond(input logic [1:0] s, input int c);
    if (s == 2'd1) return c == 256;
    if (s == 2'd2) return c != 0;
    return c >= 128;
  endfunction

  task automatic step(input bit w, input logic [7:0] d, input bit r,
                      input bit a, input bit oc, input logic [1:0] s);
    int c;
    bit cond, rise;
    wr_en = w; wr_data = d; rd_en = r; irq_ack = a; ovf_clr = oc; irq_sel = s;
    @(posedge clk);
    c = q.size();
    if (rst) begin
      q.delete(); m_ovf = 0; m_irq = 0; m_cq = 0; m_rd = 0;
    end else begin
      cond = m_cond(s, c);
      if (r && c != 0) m_rd = q.pop_front();
      if (w && c != 256) q.push_back(d);
      if (w && c == 256) m_ovf = 1; else if (oc) m_ovf = 0;
      rise = cond && !m_cq;
      m_irq = rise || (m_irq && !a);
      m_cq = cond;
    end
    @(negedge clk);
    chk("R2 empty", empty, q.size() == 0);
    chk("R2 half", half, q.size() >= 128);
    chk("R2 full", full, q.size() == 256);
    chk("R1 rd_data", rd_data, m_rd);
    chk("R3 ovf", ovf, m_ovf);
    chk("R6 irq", irq, m_irq);
  endtask

  task automatic idle(input int n, input logic [1:0] s);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, s);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] prev;
    void'($urandom(32'h1234_5678));
    @(negedge clk);
    idle(3, 0);
    rst = 0;
    chk("R9 reset empty", empty, 1);
    chk("R9 reset irq", irq, 0);
    chk("R9 reset ovf", ovf, 0);

    // R5: empty read keeps rd_data
    step(1, 8'hA5, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    prev = rd_data;
    chk("R1 first byte", rd_data, 8'hA5);
    step(0, 0, 1, 0, 0, 0);
    chk("R5 empty read holds", rd_data, prev);
    step(1, 8'h3C, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    chk("R5 next byte after empty read", rd_data, 8'h3C);

    // fill to 256 with half source
    for (int i = 0; i < 256; i++) step(1, 8'(i), 0, 0, 0, 0);
    chk("R2 full after 256", full, 1);
    chk("R7 irq held without ack", irq, 1);
    step(1, 8'hFF, 0, 0, 0, 0);
    chk("R3 overflow set", ovf, 1);
    idle(3, 0);
    chk("R3 overflow sticky", ovf, 1);
    step(1, 8'hEE, 0, 0, 1, 0);
    chk("R3 set beats clear", ovf, 1);
    step(0, 0, 0, 0, 1, 0);
    chk("R3 cleared", ovf, 0);

    // R8: ack while half stays true
    step(0, 0, 0, 1, 0, 0);
    chk("R7 ack clears irq", irq, 0);
    idle(5, 0);
    chk("R8 no retrigger while level", irq, 0);
    for (int i = 0; i < 200; i++) step(0, 0, 1, 0, 0, 0);
    chk("R8 still quiet after drain", irq, 0);
    for (int i = 0; i < 80; i++) step(1, 8'(i), 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk("R8 retrigger on new rise", irq, 1);
    step(0, 0, 0, 1, 0, 0);

    // R4: simultaneous read/write keeps occupancy
    for (int i = 0; i < 30; i++) step(1, 8'(i + 7), 1, 0, 0, 0);
    n = 0;
    while (!empty && n < 300) begin step(0, 0, 1, 0, 0, 0); n++; end
    chk("R4 occupancy unchanged by rw", n, 136);

    // R6: full and not-empty sources
    step(0, 0, 0, 1, 0, 2);
    step(1, 8'h11, 0, 0, 0, 2);
    step(0, 0, 0, 0, 0, 2);
    chk("R6 not-empty source", irq, 1);
    step(0, 0, 1, 1, 0, 1);
    for (int i = 0; i < 255; i++) step(1, 8'(i), 0, 0, 0, 1);
    chk("R6 full source quiet at 255", irq, 0);
    step(1, 8'h22, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    chk("R6 full source fires", irq, 1);

    // random phases
    for (int ph = 0; ph < 12; ph++) begin
      int wp = (ph % 2 == 0) ? 80 : 25;
      int rp = (ph % 2 == 0) ? 25 : 80;
      for (int i = 0; i < 300; i++)
        step(($urandom % 100) < wp, 8'($urandom), ($urandom % 100) < rp,
             irq && ($urandom % 8 == 0), ($urandom % 40 == 0),
             ($urandom % 60 == 0) ? 2'($urandom) : irq_sel);
    end

    // R9: reset mid-run
    step(1, 8'h5A, 0, 0, 0, 0);
    rst = 1;
    step(0, 0, 0, 0, 0, 0);
    rst = 0;
    chk("R9 reset empties", empty, 1);
    chk("R9 reset rd_data", rd_data, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule